// File: doc/BRIEF.md
# Byte-Move DMA Channel with End-of-Block Signalling

This block is a single DMA channel that sits between a peripheral's data register and a target address space. It moves one byte for each peripheral request it serves. Each move is followed by two more steps, always in this order: the target address goes up by one, then the remaining-transaction count goes down by one. The target is either a small register-file space with 8-bit addresses or a memory space with 16-bit addresses. In the receive direction the byte goes from the peripheral register to the target, as a bus write. In the transmit direction it comes from the target, as a bus read, and is written into the peripheral register.

Software arms the channel with one load pulse that carries the space, the direction, the two direction enable bits, the start address and the count. The count must fit the selected space, otherwise the load is refused. On the last transaction the channel raises the end-of-block pending bit for its direction and disarms itself. A suspend input from the arbiter freezes progress without losing state. The bus side uses a valid/ready handshake.

The state machine has four states, each named for its step of a transaction:
- `ST_IDLE` waits for a request.
- `ST_MOVE` holds the bus access.
- `ST_INCR` advances the address.
- `ST_DECR` decrements the count.

The transitions are:
- IDLE→MOVE (start): armed, request present, no suspend and no load in that cycle.
- MOVE→INCR (handshake): bus ready.
- INCR→DECR (advance): no suspend.
- DECR→IDLE (retire): no suspend.

Top module: `dma_eob_channel`

## Requirements
- R1: After reset, `bus_valid_o`, `ack_o`, `evt_o`, `pdr_wr_o`, `rx_eob_o` and `tx_eob_o` are all low.
- R2: Each transaction runs its steps in a fixed order. First comes the bus access at the current address. Then comes the address increment. Last comes the count decrement, during which `ack_o` is high for exactly one cycle. The next transaction uses the incremented address.
- R3: Direction 0 (`cfg_dir_tx_i`=0) is receive: `bus_write_o`=1 and `bus_wdata_o` equals `pdr_rdata_i`. Direction 1 is transmit: `bus_write_o`=0, and in the handshake cycle `pdr_wr_o`=1 with `pdr_wdata_o` equal to `bus_rdata_i`.
- R4: A load arms receive only if `cfg_rx_en_i`=1 and transmit only if `cfg_tx_en_i`=1. If the enable bit for the loaded direction is clear, requests start no bus access.
- R5: A load is accepted only if the count is at least 1 and at most 222 (space 0, register file) or at most 65536 (space 1, memory). A refused load leaves the channel disarmed.
- R6: On the decrement that brings the count to 0, the channel sets `rx_eob_o` (receive) or `tx_eob_o` (transmit), clears its enable, and ignores requests from then on.
- R7: `evt_o` pulses with `ack_o` on every transaction except the final one, where it stays low.
- R8: While `suspend_i` is high, no new transaction starts and a transaction in its increment or decrement step holds. Once `suspend_i` falls, work resumes at the same address and count.
- R9: In space 0 the address is 8 bits and wraps from 0xFF to 0x00, and the upper bits of a loaded address are dropped. In space 1 the address wraps from 0xFFFF to 0x0000.
- R10: A load is taken only in `ST_IDLE` and is ignored during a transaction. An accepted load clears both end-of-block pending bits.
- R11: Once raised, `bus_valid_o` stays high, with `bus_addr_o` unchanged, until `bus_ready_i` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load_i | input | 1 | Load pulse for the configuration fields |
| cfg_space_i | input | 1 | 0 register file, 1 memory |
| cfg_dir_tx_i | input | 1 | 0 receive, 1 transmit |
| cfg_rx_en_i | input | 1 | Receive path enable |
| cfg_tx_en_i | input | 1 | Transmit path enable |
| cfg_addr_i | input | MEM_AW | Start address |
| cfg_count_i | input | CW | Number of transactions |
| req_i | input | 1 | Peripheral transfer request |
| suspend_i | input | 1 | Arbiter suspend |
| pdr_rdata_i | input | DW | Peripheral data register contents |
| pdr_wr_o | output | 1 | Write strobe into peripheral data register |
| pdr_wdata_o | output | DW | Byte written to peripheral data register |
| ack_o | output | 1 | Transaction retired (decrement step) |
| evt_o | output | 1 | General per-transaction event (non-final only) |
| rx_eob_o | output | 1 | Receive end-of-block pending |
| tx_eob_o | output | 1 | Transmit end-of-block pending |
| bus_valid_o | output | 1 | Bus request valid |
| bus_ready_i | input | 1 | Bus accepts / returns data |
| bus_write_o | output | 1 | 1 write, 0 read |
| bus_space_o | output | 1 | Address space of the access |
| bus_addr_o | output | MEM_AW | Target address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid with ready |

## Verification
Two events can fall in the same cycle: the final count decrement, and a peripheral request that is still asserted and would otherwise start another transaction. The bench provokes this by holding the request high through and after the last acknowledge. It then judges that the correct pending bit rises and that no bus access follows over several cycles. A second overlap comes from raising suspend during the handshake cycle, so that it takes hold exactly as the increment step begins. The bench judges that the acknowledge is held back and that the next access still uses the next address.

// File: rtl/dma_eob_pkg.sv
package dma_eob_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_INCR = 2'd2,
        ST_DECR = 2'd3
    } dma_state_e;

endpackage

// File: rtl/dma_eob_fsm.sv
module dma_eob_fsm
    import dma_eob_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       suspend_i,
    input  logic       bus_ready_i,
    output dma_state_e state_o,
    output logic       bus_valid_o,
    output logic       step_inc_o,
    output logic       step_dec_o
);

    dma_state_e state_q, state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go_i)        state_d = ST_MOVE;
            ST_MOVE: if (bus_ready_i) state_d = ST_INCR;
            ST_INCR: if (!suspend_i)  state_d = ST_DECR;
            ST_DECR: if (!suspend_i)  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        bus_valid_o = 1'b0;
        step_inc_o  = 1'b0;
        step_dec_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_MOVE: bus_valid_o = 1'b1;
            ST_INCR: step_inc_o  = !suspend_i;
            ST_DECR: step_dec_o  = !suspend_i;
            default: ;
        endcase
    end

    assign state_o = state_q;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> bus_valid_o); // R11

    AST_NO_START_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i && state_q == ST_IDLE |=> state_q != ST_MOVE); // R8

    AST_DEC_AFTER_INC: assert property (@(posedge clk) disable iff (!rst_n)
        step_dec_o |-> $past(state_q) inside {ST_INCR, ST_DECR}); // R2

endmodule

// File: rtl/dma_eob_regs.sv
module dma_eob_regs #(
    parameter int RF_AW   = 8,
    parameter int MEM_AW  = 16,
    parameter int RF_MAX  = 222,
    parameter int MEM_MAX = 65536,
    parameter int CW      = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              cfg_space_i,
    input  logic              cfg_dir_tx_i,
    input  logic              cfg_rx_en_i,
    input  logic              cfg_tx_en_i,
    input  logic [MEM_AW-1:0] cfg_addr_i,
    input  logic [CW-1:0]     cfg_count_i,
    input  logic              step_inc_i,
    input  logic              step_dec_i,
    input  logic              suspend_i,
    output logic [MEM_AW-1:0] addr_o,
    output logic              space_o,
    output logic              dir_tx_o,
    output logic              active_o,
    output logic              last_o,
    output logic              rx_eob_o,
    output logic              tx_eob_o
);

    localparam logic [MEM_AW-1:0] RF_MASK = {{(MEM_AW-RF_AW){1'b0}}, {RF_AW{1'b1}}};
    localparam logic [CW-1:0]     RF_LIM  = CW'(RF_MAX);
    localparam logic [CW-1:0]     MEM_LIM = CW'(MEM_MAX);

    logic [MEM_AW-1:0] addr_q, addr_inc, load_addr;
    logic [CW-1:0]     cnt_q;
    logic              space_q, dir_tx_q, arm_rx_q, arm_tx_q, rx_eob_q, tx_eob_q;
    logic              limit_ok;

    assign limit_ok  = (cfg_count_i != '0) &&
                       (cfg_count_i <= (cfg_space_i ? MEM_LIM : RF_LIM));
    assign load_addr = cfg_space_i ? cfg_addr_i : (cfg_addr_i & RF_MASK);
    assign addr_inc  = space_q ? (addr_q + 1'b1) : ((addr_q + 1'b1) & RF_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            cnt_q    <= '0;
            space_q  <= 1'b0;
            dir_tx_q <= 1'b0;
            arm_rx_q <= 1'b0;
            arm_tx_q <= 1'b0;
            rx_eob_q <= 1'b0;
            tx_eob_q <= 1'b0;
        end else if (load_i) begin
            rx_eob_q <= 1'b0;
            tx_eob_q <= 1'b0;
            arm_rx_q <= cfg_rx_en_i && limit_ok;
            arm_tx_q <= cfg_tx_en_i && limit_ok;
            if (limit_ok) begin
                addr_q   <= load_addr;
                cnt_q    <= cfg_count_i;
                space_q  <= cfg_space_i;
                dir_tx_q <= cfg_dir_tx_i;
            end
        end else begin
            if (step_inc_i) addr_q <= addr_inc;
            if (step_dec_i) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    if (dir_tx_q) begin
                        arm_tx_q <= 1'b0;
                        tx_eob_q <= 1'b1;
                    end else begin
                        arm_rx_q <= 1'b0;
                        rx_eob_q <= 1'b1;
                    end
                end
            end
        end
    end

    assign addr_o   = addr_q;
    assign space_o  = space_q;
    assign dir_tx_o = dir_tx_q;
    assign active_o = dir_tx_q ? arm_tx_q : arm_rx_q;
    assign last_o   = (cnt_q == CW'(1));
    assign rx_eob_o = rx_eob_q;
    assign tx_eob_o = tx_eob_q;

    AST_RF_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !space_q |-> (addr_q & ~RF_MASK) == '0); // R9

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> cnt_q != '0 && cnt_q <= (space_q ? MEM_LIM : RF_LIM)); // R5

    AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_i && !load_i |=> $stable(addr_q) && $stable(cnt_q)); // R8

    AST_EOB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_eob_q, tx_eob_q})); // R6

    AST_EOB_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_eob_q) || $rose(tx_eob_q) |-> !active_o); // R6

endmodule

// File: rtl/dma_eob_channel.sv
module dma_eob_channel
    import dma_eob_pkg::*;
#(
    parameter int RF_AW   = 8,
    parameter int MEM_AW  = 16,
    parameter int DW      = 8,
    parameter int RF_MAX  = 222,
    parameter int MEM_MAX = 65536,
    parameter int CW      = $clog2(MEM_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load_i,
    input  logic              cfg_space_i,
    input  logic              cfg_dir_tx_i,
    input  logic              cfg_rx_en_i,
    input  logic              cfg_tx_en_i,
    input  logic [MEM_AW-1:0] cfg_addr_i,
    input  logic [CW-1:0]     cfg_count_i,
    input  logic              req_i,
    input  logic              suspend_i,
    input  logic [DW-1:0]     pdr_rdata_i,
    output logic              pdr_wr_o,
    output logic [DW-1:0]     pdr_wdata_o,
    output logic              ack_o,
    output logic              evt_o,
    output logic              rx_eob_o,
    output logic              tx_eob_o,
    output logic              bus_valid_o,
    input  logic              bus_ready_i,
    output logic              bus_write_o,
    output logic              bus_space_o,
    output logic [MEM_AW-1:0] bus_addr_o,
    output logic [DW-1:0]     bus_wdata_o,
    input  logic [DW-1:0]     bus_rdata_i
);

    dma_state_e state;
    logic       go, load_ok, step_inc, step_dec;
    logic       active, last, dir_tx, space;

    assign load_ok = cfg_load_i && (state == ST_IDLE);
    assign go      = active && req_i && !suspend_i && !cfg_load_i;

    dma_eob_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (go),
        .suspend_i   (suspend_i),
        .bus_ready_i (bus_ready_i),
        .state_o     (state),
        .bus_valid_o (bus_valid_o),
        .step_inc_o  (step_inc),
        .step_dec_o  (step_dec)
    );

    dma_eob_regs #(
        .RF_AW   (RF_AW),
        .MEM_AW  (MEM_AW),
        .RF_MAX  (RF_MAX),
        .MEM_MAX (MEM_MAX),
        .CW      (CW)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_ok),
        .cfg_space_i  (cfg_space_i),
        .cfg_dir_tx_i (cfg_dir_tx_i),
        .cfg_rx_en_i  (cfg_rx_en_i),
        .cfg_tx_en_i  (cfg_tx_en_i),
        .cfg_addr_i   (cfg_addr_i),
        .cfg_count_i  (cfg_count_i),
        .step_inc_i   (step_inc),
        .step_dec_i   (step_dec),
        .suspend_i    (suspend_i),
        .addr_o       (bus_addr_o),
        .space_o      (space),
        .dir_tx_o     (dir_tx),
        .active_o     (active),
        .last_o       (last),
        .rx_eob_o     (rx_eob_o),
        .tx_eob_o     (tx_eob_o)
    );

    assign bus_write_o = !dir_tx;
    assign bus_space_o = space;
    assign bus_wdata_o = pdr_rdata_i;
    assign pdr_wdata_o = bus_rdata_i;
    assign pdr_wr_o    = bus_valid_o && bus_ready_i && dir_tx;
    assign ack_o       = step_dec;
    assign evt_o       = step_dec && !last;

    AST_EVT_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> ack_o); // R7

    AST_EOB_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_eob_o) || $rose(tx_eob_o) |-> $past(ack_o) && !$past(evt_o)); // R7

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o && !bus_ready_i |=> $stable(bus_addr_o)); // R11

endmodule

// File: tb/dma_eob_channel_bench.sv
module dma_eob_channel_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 0, cfg_space = 0, cfg_dir_tx = 0, cfg_rx_en = 0, cfg_tx_en = 0;
    logic [15:0] cfg_addr = '0;
    logic [16:0] cfg_count = '0;
    logic        req = 0, suspend = 0, rdy = 1;
    logic [7:0]  pdr_rdata = 8'h00;
    logic        pdr_wr, ack, evt, rx_eob, tx_eob, bus_valid, bus_write, bus_space;
    logic [7:0]  pdr_wdata, bus_wdata, bus_rdata;
    logic [15:0] bus_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model: read data derived from address
    assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

    dma_eob_channel u_dma_eob_channel (
        .clk(clk), .rst_n(rst_n),
        .cfg_load_i(cfg_load), .cfg_space_i(cfg_space), .cfg_dir_tx_i(cfg_dir_tx),
        .cfg_rx_en_i(cfg_rx_en), .cfg_tx_en_i(cfg_tx_en),
        .cfg_addr_i(cfg_addr), .cfg_count_i(cfg_count),
        .req_i(req), .suspend_i(suspend), .pdr_rdata_i(pdr_rdata),
        .pdr_wr_o(pdr_wr), .pdr_wdata_o(pdr_wdata), .ack_o(ack), .evt_o(evt),
        .rx_eob_o(rx_eob), .tx_eob_o(tx_eob), .bus_valid_o(bus_valid),
        .bus_ready_i(rdy), .bus_write_o(bus_write), .bus_space_o(bus_space),
        .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata)
    );

    // {space, dir_tx, addr[15:0], count[16:0]}
    localparam logic [34:0] VEC [5] = '{
        {1'b0, 1'b0, 16'h0010, 17'd3},
        {1'b0, 1'b1, 16'h12FE, 17'd3},
        {1'b1, 1'b0, 16'hFFFE, 17'd3},
        {1'b1, 1'b1, 16'h4000, 17'd2},
        {1'b0, 1'b1, 16'h0080, 17'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input logic sp, input logic dt, input logic rxe, input logic txe,
                        input logic [15:0] ad, input logic [16:0] cn);
        @(negedge clk);
        cfg_space = sp; cfg_dir_tx = dt; cfg_rx_en = rxe; cfg_tx_en = txe;
        cfg_addr = ad; cfg_count = cn; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_valid(input string tag);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (bus_valid) break;
        end
        chk(tag, bus_valid, 1'b1);
    endtask

    task automatic wait_ack(input string tag);
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (ack) break;
        end
        chk(tag, ack, 1'b1);
    endtask

    // watch for any bus access over a window
    task automatic quiet(input string tag, input int cycles);
        logic seen;
        seen = 1'b0;
        for (int n = 0; n < cycles; n++) begin
            @(negedge clk);
            if (bus_valid) seen = 1'b1;
        end
        chk(tag, seen, 1'b0);
    endtask

    task automatic xfer(input logic [15:0] ea, input logic tx, input logic last);
        req = 1'b1;
        wait_valid("R2");
        chk("R2", bus_addr, ea);
        chk("R3", bus_write, !tx);
        if (tx) begin
            chk("R3", pdr_wr, 1'b1);
            chk("R3", pdr_wdata, ea[7:0] ^ 8'hA5);
        end else begin
            chk("R3", bus_wdata, pdr_rdata);
        end
        wait_ack("R2");
        chk("R7", evt, !last);
        req = 1'b0;
        @(negedge clk);
        chk("R6", tx ? tx_eob : rx_eob, last);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", {bus_valid, ack, evt, pdr_wr, rx_eob, tx_eob}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {bus_valid, ack, evt, rx_eob, tx_eob}, 5'b0);

        // vector table
        for (int i = 0; i < 5; i++) begin
            logic        sp, dt;
            logic [15:0] ad, ea;
            logic [16:0] cn;
            sp = VEC[i][34]; dt = VEC[i][33]; ad = VEC[i][32:17]; cn = VEC[i][16:0];
            pdr_rdata = 8'h30 + 8'(i);
            load(sp, dt, !dt, dt, ad, cn);
            for (int k = 0; k < int'(cn); k++) begin
                ea = sp ? (ad + 16'(k)) : {8'h00, ad[7:0] + 8'(k)}; // R9 wrap
                xfer(ea, dt, k == int'(cn) - 1);
            end
            // R6: request still asserted after end of block
            req = 1'b1;
            quiet("R6", 8);
            req = 1'b0;
        end

        // R10: accepted load clears pending bit left by previous vector
        load(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 17'd1);
        chk("R10", {rx_eob, tx_eob}, 2'b00);

        // R4: direction enable clear -> no service
        load(1'b0, 1'b0, 1'b0, 1'b1, 16'h0020, 17'd2);
        req = 1'b1;
        quiet("R4", 8);
        req = 1'b0;

        // R5: limits
        load(1'b0, 1'b0, 1'b1, 1'b0, 16'h0000, 17'd223);
        req = 1'b1; quiet("R5", 8); req = 1'b0;
        load(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 17'd65537);
        req = 1'b1; quiet("R5", 8); req = 1'b0;
        load(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 17'd0);
        req = 1'b1; quiet("R5", 8); req = 1'b0;
        load(1'b0, 1'b0, 1'b1, 1'b0, 16'h0040, 17'd222);
        xfer(16'h0040, 1'b0, 1'b0);
        load(1'b1, 1'b1, 1'b0, 1'b1, 16'h0700, 17'd65536);
        xfer(16'h0700, 1'b1, 1'b0);

        // R8: suspend before start and during increment step
        load(1'b1, 1'b0, 1'b1, 1'b0, 16'h0100, 17'd2);
        suspend = 1'b1; req = 1'b1;
        quiet("R8", 6);
        suspend = 1'b0;
        wait_valid("R8");
        chk("R8", bus_addr, 16'h0100);
        suspend = 1'b1;                   // lands as the increment step begins
        seen = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (ack || bus_valid) seen = 1'b1;
        end
        chk("R8", seen, 1'b0);
        suspend = 1'b0;
        wait_ack("R8");
        chk("R8", evt, 1'b1);
        xfer(16'h0101, 1'b0, 1'b1);

        // R11 / R10: bus stall, load ignored mid-transaction
        load(1'b1, 1'b1, 1'b0, 1'b1, 16'h2000, 17'd2);
        rdy = 1'b0; req = 1'b1;
        wait_valid("R11");
        cfg_space = 1'b1; cfg_addr = 16'h3333; cfg_count = 17'd5; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        seen = 1'b0;
        for (int n = 0; n < 3; n++) begin
            if (!bus_valid || bus_addr != 16'h2000) seen = 1'b1;
            @(negedge clk);
        end
        chk("R11", seen, 1'b0);
        rdy = 1'b1;
        wait_ack("R11");
        req = 1'b0;
        @(negedge clk);
        xfer(16'h2001, 1'b1, 1'b1);      // R10: address kept from first load
        chk("R10", tx_eob, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule